// File: doc/BRIEF.md
# Hash Engine Bus Register Front End

This block sits between a simple single-cycle processor bus and a block-chained hash compression engine of the SHA-1 kind. Software loads a 512-bit message block as sixteen 32-bit words, starts the engine with a write to a control word, and polls a status word. Once the engine reports a valid result, software reads the 160-bit digest as five 32-bit words. The block word and digest word windows are big-endian: the lowest address holds the most significant word.

A control write turns each command bit into a start pulse exactly one clock long. One bit starts a new message. The other bit continues a message from the previous digest. The bank also returns three fixed identification words. Reads of addresses that hold nothing return zero. The engine's block input is driven directly by the word registers, and its digest output is read directly through the read path, so no copies are held.

Top module: `hash_reg_front`

## Requirements
- R1: With `bus_sel`=1 and `bus_we`=1, the word on `bus_wdata` is written at `bus_addr` on the rising clock edge. With `bus_sel`=1 and `bus_we`=0, the addressed word appears on `bus_rdata` in the same cycle, without waiting for a clock edge. At all other times `bus_rdata` is zero.
- R2: Address 0x00 reads 0x68617368, 0x01 reads 0x72656773 and 0x02 reads 0x312E3030. Writes to these three addresses are ignored.
- R3: The control word is at 0x08. Bit 0 starts a new message and bit 1 continues the current one. A read returns the two stored bits in bits 1:0, with zeros above.
- R4: `eng_start` (bit 0) and `eng_cont` (bit 1) go high for exactly one clock, in the cycle after the edge that captured a control write which changed that bit from 0 to 1. A control write that leaves the bit at 1 gives no pulse.
- R5: The status word is at 0x09. Bit 0 is `eng_ready`, bit 1 is `eng_digest_vld`, and the other bits are zero. Writes to it are ignored.
- R6: The block words are at 0x10 to 0x1F. Address 0x10+k drives `eng_block` bits [511-32k : 480-32k], so 0x10 is the top word and 0x1F is bits 31:0. Each word reads back as written.
- R7: The digest words are at 0x20 to 0x24. Address 0x20+k returns `eng_digest` bits [159-32k : 128-32k]. Writes to these addresses are ignored.
- R8: A read of any other address returns zero. A write to any other address changes no register.
- R9: `rst_n` is active-low and asynchronous. It clears the control word, all block words and both command pulses without waiting for a clock edge.
- R10: The software sequence works end to end with a chained engine. The sequence is: load the block, write 0x01 (or 0x02) then 0x00 to control, poll status until it is non-zero, then read the digest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus transaction select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| eng_start | output | 1 | One-clock pulse: begin a new message |
| eng_cont | output | 1 | One-clock pulse: chain the next block |
| eng_block | output | 512 | Message block toward the engine |
| eng_ready | input | 1 | Engine idle and able to accept a command |
| eng_digest | input | 160 | Digest from the engine |
| eng_digest_vld | input | 1 | Digest is valid |

## Verification
The hardest case to reach from the ports is a second control write that keeps a command bit set. It must give no new pulse, even though the engine is still busy with the first command. The bench writes the start bit twice in a row before clearing it, and samples the pulse outputs at each intervening negative edge. Word order is the other subtle point. The bench loads distinct words into every block slot and drives a behavioural engine stub whose digest depends on the block position by position. A digest read back in the wrong order, or taken from the wrong block slot, therefore differs from the value the bench computes for both a starting block and a chained block.

// File: rtl/hrf_pkg.sv
`timescale 1ns/1ps
package hrf_pkg;
  // word addresses of the bank (behaviour depends on them: software map)
  localparam int A_NAME_HI = 8'h00;
  localparam int A_NAME_LO = 8'h01;
  localparam int A_VERSION = 8'h02;
  localparam int A_CTRL    = 8'h08;
  localparam int A_STAT    = 8'h09;
  localparam int A_BLK0    = 8'h10;
  localparam int A_DIG0    = 8'h20;

  localparam logic [31:0] ID_NAME_HI = 32'h6861_7368; // "hash"
  localparam logic [31:0] ID_NAME_LO = 32'h7265_6773; // "regs"
  localparam logic [31:0] ID_VERSION = 32'h312e_3030; // "1.00"

  // control bit positions
  localparam int CB_START = 0;
  localparam int CB_CONT  = 1;

  // big-endian window: word index k of n words of width w sits at this lsb
  function automatic int word_lsb(int k, int n, int w);
    return (n - 1 - k) * w;
  endfunction

  // true when address a falls in [base, base+n)
  function automatic logic in_window(int a, int base, int n);
    return (a >= base) && (a < base + n);
  endfunction
endpackage

// File: rtl/hrf_cmd_ctrl.sv
`timescale 1ns/1ps
module hrf_cmd_ctrl #(
  parameter int CMD_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ctrl,
  input  logic [CMD_BITS-1:0] wbits,
  output logic [CMD_BITS-1:0] ctrl_q,
  output logic [CMD_BITS-1:0] pulse_q
);
  // a bit that rises through a write gives one pulse; holding it gives none
  logic [CMD_BITS-1:0] rise_bits;
  assign rise_bits = wbits & ~ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      pulse_q <= '0;
    end else begin
      pulse_q <= wr_ctrl ? rise_bits : '0;
      if (wr_ctrl) ctrl_q <= wbits;
    end
  end
endmodule

// File: rtl/hrf_block_bank.sv
`timescale 1ns/1ps
module hrf_block_bank #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 16,
  localparam int BLK_W = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORDS-1:0]  word_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [BLK_W-1:0]  block_o
);
  import hrf_pkg::*;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          word_q <= '0;
      else if (word_we[i]) word_q <= wdata;
    end
    assign block_o[word_lsb(i, WORDS, DATA_W) +: DATA_W] = word_q;
  end
endmodule

// File: rtl/hrf_read_mux.sv
`timescale 1ns/1ps
module hrf_read_mux #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int BLK_WORDS = 16,
  parameter int DIG_WORDS = 5,
  localparam int BLK_W = DATA_W * BLK_WORDS,
  localparam int DIG_W = DATA_W * DIG_WORDS
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        ctrl_bits,
  input  logic              ready,
  input  logic              digest_vld,
  input  logic [BLK_W-1:0]  block,
  input  logic [DIG_W-1:0]  digest,
  output logic [DATA_W-1:0] rdata,
  output logic              unmapped
);
  import hrf_pkg::*;

  logic hit;
  int   ai;

  always_comb begin
    ai    = int'(addr);
    rdata = '0;
    hit   = 1'b1;
    if (ai == A_NAME_HI)      rdata = DATA_W'(ID_NAME_HI);
    else if (ai == A_NAME_LO) rdata = DATA_W'(ID_NAME_LO);
    else if (ai == A_VERSION) rdata = DATA_W'(ID_VERSION);
    else if (ai == A_CTRL)    rdata = DATA_W'(ctrl_bits);
    else if (ai == A_STAT)    rdata = DATA_W'({digest_vld, ready});
    else if (in_window(ai, A_BLK0, BLK_WORDS)) begin
      for (int k = 0; k < BLK_WORDS; k++)
        if (ai == A_BLK0 + k) rdata = block[word_lsb(k, BLK_WORDS, DATA_W) +: DATA_W];
    end else if (in_window(ai, A_DIG0, DIG_WORDS)) begin
      for (int k = 0; k < DIG_WORDS; k++)
        if (ai == A_DIG0 + k) rdata = digest[word_lsb(k, DIG_WORDS, DATA_W) +: DATA_W];
    end else hit = 1'b0;
    if (!rd_en) begin
      rdata = '0;
      hit   = 1'b1;
    end
    unmapped = ~hit;
  end
endmodule

// File: rtl/hash_reg_front.sv
`timescale 1ns/1ps
module hash_reg_front #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int BLK_WORDS = 16,
  parameter int DIG_WORDS = 5,
  localparam int BLK_W = DATA_W * BLK_WORDS,
  localparam int DIG_W = DATA_W * DIG_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              eng_start,
  output logic              eng_cont,
  output logic [BLK_W-1:0]  eng_block,
  input  logic              eng_ready,
  input  logic [DIG_W-1:0]  eng_digest,
  input  logic              eng_digest_vld
);
  import hrf_pkg::*;

  // named internal events
  logic                 bus_wr;
  logic                 bus_rd;
  logic                 wr_ctrl;
  logic [BLK_WORDS-1:0] blk_we;
  logic [1:0]           ctrl_bits;
  logic [1:0]           cmd_pulse;
  logic                 rd_unmapped;

  assign bus_wr  = bus_sel & bus_we;
  assign bus_rd  = bus_sel & ~bus_we;
  assign wr_ctrl = bus_wr & (int'(bus_addr) == A_CTRL);

  for (genvar i = 0; i < BLK_WORDS; i++) begin : g_we
    assign blk_we[i] = bus_wr & (int'(bus_addr) == A_BLK0 + i);
  end

  hrf_cmd_ctrl #(.CMD_BITS(2)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (wr_ctrl),
    .wbits   (bus_wdata[1:0]),
    .ctrl_q  (ctrl_bits),
    .pulse_q (cmd_pulse)
  );

  assign eng_start = cmd_pulse[CB_START];
  assign eng_cont  = cmd_pulse[CB_CONT];

  hrf_block_bank #(.DATA_W(DATA_W), .WORDS(BLK_WORDS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .word_we (blk_we),
    .wdata   (bus_wdata),
    .block_o (eng_block)
  );

  hrf_read_mux #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_WORDS(BLK_WORDS), .DIG_WORDS(DIG_WORDS)
  ) u_rd (
    .rd_en      (bus_rd),
    .addr       (bus_addr),
    .ctrl_bits  (ctrl_bits),
    .ready      (eng_ready),
    .digest_vld (eng_digest_vld),
    .block      (eng_block),
    .digest     (eng_digest),
    .rdata      (bus_rdata),
    .unmapped   (rd_unmapped)
  );
endmodule

// File: rtl/hash_reg_front_chk.sv
`timescale 1ns/1ps
module hash_reg_front_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int BLK_W  = 512,
  parameter int DIG_W  = 160
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        wbits,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              eng_start,
  input logic              eng_cont,
  input logic [BLK_W-1:0]  eng_block,
  input logic              eng_ready,
  input logic [DIG_W-1:0]  eng_digest,
  input logic              eng_digest_vld,
  input logic              rd_unmapped
);
  import hrf_pkg::*;

  logic rd_now, ctl_wr_now;
  assign rd_now     = bus_sel && !bus_we;
  assign ctl_wr_now = bus_sel && bus_we && (int'(bus_addr) == A_CTRL);

  p_start_one_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  p_cont_one_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cont |=> !eng_cont);
  p_start_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(ctl_wr_now && wbits[0]));
  p_cont_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cont |-> $past(ctl_wr_now && wbits[1]));
  p_idle_rdata_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_now |-> (bus_rdata == '0));
  p_block_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we) |=> $stable(eng_block));
  p_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && int'(bus_addr) == A_STAT) |-> (bus_rdata == DATA_W'({eng_digest_vld, eng_ready})));
  p_digest_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && int'(bus_addr) == A_DIG0) |-> (bus_rdata == eng_digest[DIG_W-1 -: DATA_W]));
  p_name_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_now && int'(bus_addr) == A_NAME_HI) |-> (bus_rdata == DATA_W'(ID_NAME_HI)));
  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |-> (bus_rdata == '0));
endmodule

bind hash_reg_front hash_reg_front_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_W(BLK_W), .DIG_W(DIG_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_sel        (bus_sel),
  .bus_we         (bus_we),
  .bus_addr       (bus_addr),
  .wbits          (bus_wdata[1:0]),
  .bus_rdata      (bus_rdata),
  .eng_start      (eng_start),
  .eng_cont       (eng_cont),
  .eng_block      (eng_block),
  .eng_ready      (eng_ready),
  .eng_digest     (eng_digest),
  .eng_digest_vld (eng_digest_vld),
  .rd_unmapped    (rd_unmapped)
);

// File: tb/hash_reg_front_bench.sv
`timescale 1ns/1ps
module hash_reg_front_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel = 1'b0;
  logic         we = 1'b0;
  logic [7:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         start_p, cont_p;
  logic [511:0] blk;
  logic         rdy;
  logic         vld;
  logic [159:0] dig;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  hash_reg_front u_hash_reg_front (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .eng_start(start_p), .eng_cont(cont_p),
    .eng_block(blk), .eng_ready(rdy), .eng_digest(dig), .eng_digest_vld(vld)
  );

  // bench model of a chained engine
  function automatic logic [159:0] mdl_start(logic [511:0] b);
    return b[511:352] ^ b[159:0];
  endfunction
  function automatic logic [159:0] mdl_cont(logic [159:0] d, logic [511:0] b);
    return {d[158:0], d[159]} ^ b[159:0];
  endfunction

  // behavioural engine stub: 8 busy cycles per command
  int           stub_cnt;
  logic [511:0] stub_blk;
  logic         stub_chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy <= 1'b1; vld <= 1'b0; dig <= '0; stub_cnt <= 0;
      stub_blk <= '0; stub_chain <= 1'b0;
    end else if (start_p || cont_p) begin
      rdy <= 1'b0; vld <= 1'b0; stub_cnt <= 8;
      stub_blk <= blk; stub_chain <= cont_p;
    end else if (stub_cnt > 0) begin
      stub_cnt <= stub_cnt - 1;
      if (stub_cnt == 1) begin
        rdy <= 1'b1; vld <= 1'b1;
        dig <= stub_chain ? mdl_cont(dig, stub_blk) : mdl_start(stub_blk);
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<=50000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, string what, logic [159:0] act, logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic bus_idle();
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic read_digest(output logic [159:0] d);
    logic [31:0] w;
    d = '0;
    for (int k = 0; k < 5; k++) begin
      bus_rd(8'h20 + 8'(k), w);
      d = {d[127:0], w};
    end
  endtask

  task automatic poll_done(string req);
    logic [31:0] s;
    s = '0;
    for (int n = 0; n < 64 && s == 0; n++) bus_rd(8'h09, s);
    chk(req, "status after poll", 160'(s), 160'h3);
  endtask

  // {write, addr, data, expected read}
  localparam logic [72:0] VEC [0:17] = '{
    {1'b1, 8'h10, 32'h1111_1111, 32'h0},          // R6 top word
    {1'b1, 8'h1F, 32'hFFFF_0000, 32'h0},          // R6 bottom word
    {1'b0, 8'h10, 32'h0, 32'h1111_1111},          // R6, R1
    {1'b0, 8'h1F, 32'h0, 32'hFFFF_0000},          // R6
    {1'b0, 8'h11, 32'h0, 32'h0},                  // R6 untouched word
    {1'b1, 8'h00, 32'hDEAD_BEEF, 32'h0},          // R2 write ignored
    {1'b0, 8'h00, 32'h0, 32'h6861_7368},          // R2
    {1'b0, 8'h01, 32'h0, 32'h7265_6773},          // R2
    {1'b1, 8'h02, 32'h0, 32'h0},                  // R2 write ignored
    {1'b0, 8'h02, 32'h0, 32'h312E_3030},          // R2
    {1'b1, 8'h40, 32'h1234_5678, 32'h0},          // R8 write to hole
    {1'b0, 8'h40, 32'h0, 32'h0},                  // R8
    {1'b0, 8'h0A, 32'h0, 32'h0},                  // R8
    {1'b0, 8'h09, 32'h0, 32'h1},                  // R5 idle: ready only
    {1'b1, 8'h09, 32'hFFFF_FFFF, 32'h0},          // R5 write ignored
    {1'b0, 8'h09, 32'h0, 32'h1},                  // R5
    {1'b0, 8'h08, 32'h0, 32'h0},                  // R3 cleared
    {1'b0, 8'h25, 32'h0, 32'h0}                   // R8 past digest window
  };

  initial begin
    logic [31:0]  r;
    logic [159:0] d0, d1, exp_d;
    logic [511:0] b0, b1;

    // R9 reset state, during reset
    #12;
    chk("R9", "start in reset", 160'(start_p), 160'h0);
    chk("R9", "block in reset", 160'(blk[511:352] | blk[159:0]), 160'h0);
    @(negedge clk); rst_n = 1'b1;
    bus_rd(8'h08, r); chk("R9", "ctrl after reset", 160'(r), 160'h0);
    bus_idle();
    chk("R1", "rdata when idle", 160'(rdata), 160'h0);

    for (int i = 0; i < 18; i++) begin
      if (VEC[i][72]) bus_wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        bus_rd(VEC[i][71:64], r);
        chk("table", $sformatf("vec %0d addr %h", i, VEC[i][71:64]), 160'(r), 160'(VEC[i][31:0]));
      end
    end
    bus_idle();

    // R4 pulse length and no repeat while bit held
    bus_wr(8'h08, 32'h1);
    @(negedge clk); sel = 1'b0; #1;
    chk("R4", "start pulse", 160'(start_p), 160'h1);
    chk("R4", "cont quiet", 160'(cont_p), 160'h0);
    @(negedge clk); #1;
    chk("R4", "start one clock", 160'(start_p), 160'h0);
    bus_wr(8'h08, 32'h1);
    @(negedge clk); sel = 1'b0; #1;
    chk("R4", "held bit no pulse", 160'(start_p), 160'h0);
    bus_rd(8'h08, r); chk("R3", "ctrl reads start", 160'(r), 160'h1);
    bus_wr(8'h08, 32'h0);
    bus_wr(8'h08, 32'h2);
    @(negedge clk); sel = 1'b0; #1;
    chk("R4", "cont pulse", 160'(cont_p), 160'h1);
    bus_rd(8'h08, r); chk("R3", "ctrl reads cont", 160'(r), 160'h2);
    bus_wr(8'h08, 32'h0);
    poll_done("R5");

    // R10 end to end: start block then chained block
    for (int k = 0; k < 16; k++) begin
      b0[(15-k)*32 +: 32] = 32'hA500_0000 ^ (32'(k) * 32'h0101_0101) ^ 32'h0000_00F0;
      bus_wr(8'h10 + 8'(k), b0[(15-k)*32 +: 32]);
    end
    chk("R6", "block port order", 160'(blk[511:352]), 160'(b0[511:352]));
    bus_wr(8'h08, 32'h1);
    bus_wr(8'h08, 32'h0);
    bus_rd(8'h09, r); chk("R5", "busy status", 160'(r), 160'h0);
    poll_done("R10");
    read_digest(d0);
    exp_d = mdl_start(b0);
    chk("R10", "start digest", d0, exp_d);
    bus_wr(8'h20, 32'h0);
    bus_wr(8'h24, 32'h0);
    bus_rd(8'h20, r); chk("R7", "digest write ignored top", 160'(r), 160'(exp_d[159:128]));
    bus_rd(8'h24, r); chk("R7", "digest write ignored bottom", 160'(r), 160'(exp_d[31:0]));
    for (int k = 0; k < 16; k++) begin
      b1[(15-k)*32 +: 32] = 32'h3C00_0000 + 32'(k * 77);
      bus_wr(8'h10 + 8'(k), b1[(15-k)*32 +: 32]);
    end
    bus_wr(8'h08, 32'h2);
    bus_wr(8'h08, 32'h0);
    poll_done("R10");
    read_digest(d1);
    chk("R10", "chained digest", d1, mdl_cont(exp_d, b1));

    // R9 asynchronous reset between edges
    bus_wr(8'h08, 32'h2);
    bus_idle();
    #2 rst_n = 1'b0;
    #1;
    chk("R9", "block cleared async", 160'(blk[511:352] | blk[159:0]), 160'h0);
    chk("R9", "cont cleared async", 160'(cont_p), 160'h0);
    @(negedge clk); rst_n = 1'b1;
    bus_rd(8'h08, r); chk("R9", "ctrl cleared", 160'(r), 160'h0);
    bus_rd(8'h1F, r); chk("R9", "word cleared", 160'(r), 160'h0);
    bus_idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule